// File: doc/BRIEF.md
# Broadcast Memory Bank Leaf

This block is one leaf of a distributed memory built from many small banks. An upstream fan-out network copies every request word to every leaf, so each leaf sees the whole request stream. A leaf compares the bank-select field of each request address with its own bank identifier. It touches its local synchronous RAM only when the two are equal.

Order is kept across all leaves without tags. Every leaf answers every read with exactly one response word. That word is the stored data when the leaf owns the address and an all-zero sync word when it does not. A downstream merge tree can then OR the responses of all leaves word by word. Writes produce no response on any leaf. A leaf that does not own a write still takes its data word from the stream and discards it.

Inside the leaf, the address stage and the response stage are decoupled by a small FIFO of per-read hit flags. This lets several reads be in flight while the RAM latency elapses. A credit counter bounds the number of outstanding reads, so a stalled response port pushes back onto the request port and no response is ever lost.

Top module: `bcast_bank_leaf`

## Requirements
- R1: Every accepted read header produces exactly one response word, and no response appears for which no read was accepted.
- R2: A request word whose `req_more` bit is 1 is a write header. The next accepted word is its data word and is always accepted (`req_ready` high). The data word is stored at the header's index when the header's bank field matches, and no response is produced for it.
- R3: Bits [IDX_W-1:0] of a header select the RAM word. Bits [IDX_W+BANK_W-1:IDX_W] are compared with `bank_id`.
- R4: A read whose bank field equals `bank_id` returns the word last written to that index.
- R5: A read whose bank field differs from `bank_id` returns an all-zero word.
- R6: Responses leave in the same order as their reads were accepted, including zero sync words.
- R7: A read accepted directly after a write to the same index of this bank returns the newly written value.
- R8: At most OUTSTANDING reads are pending, counted from header acceptance to response handshake. While that many are pending and a header is expected, `req_ready` is low.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` holds its value.
- R10: In the first cycle after reset, `rsp_valid` is low and `req_ready` is high.
- R11: Header bits above the bank field, such as the request-type nibble, have no effect on the result.
- R12: A write whose bank field differs from `bank_id` leaves every RAM word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_id | input | BANK_W | Identifier of this leaf, held static |
| req_valid | input | 1 | Request word valid |
| req_ready | output | 1 | Request word accepted when high together with valid |
| req_data | input | DATA_W | Request word (header or write data) |
| req_more | input | 1 | 1 when another word of the same packet follows |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Downstream accepts the response word |
| rsp_data | output | DATA_W | Read data or zero sync word |

## Verification
On every cycle the assertions check that pending reads never exceed the credit limit and that the request port stalls at that limit. They also check that a write data word is never refused, that a held response keeps its value, that no response appears without a pending read, and that the port is quiet just after reset. Which word each response carries only shows up in the bench's scenarios. Those scenarios cover matched data versus zero sync words for every bank and index, in-order delivery under random back-pressure, read-after-write at the same index, non-owned writes that must not disturb stored words, and header bits that must be ignored.

// File: rtl/bbl_pkg.sv
package bbl_pkg;

    // Default geometry of a leaf
    localparam int DEF_DATA_W      = 32;
    localparam int DEF_IDX_W       = 11;
    localparam int DEF_BANK_W      = 17;
    localparam int DEF_OUTSTANDING = 4;
    localparam int DEF_RAM_LAT     = 2;

    // Position in a two-word write packet
    typedef enum logic {
        PH_HEAD  = 1'b0,
        PH_WDATA = 1'b1
    } req_phase_e;

    // True while another read may be issued
    function automatic logic has_room(input int unsigned used, input int unsigned cap);
        return used < cap;
    endfunction

    // Bitwise mask that keeps a word on a hit and clears it on a miss
    function automatic logic [63:0] hit_mask(input logic hit);
        return hit ? {64{1'b1}} : {64{1'b0}};
    endfunction

endpackage

// File: rtl/bbl_sync_fifo.sv
module bbl_sync_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    fill;

    logic do_push;
    logic do_pop;

    assign do_pop  = pop && (fill != '0);
    assign do_push = push;

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign out_valid = (fill != '0);
    assign out_data  = slots[rd_ptr];

endmodule

// File: rtl/bbl_bank_ram.sv
module bbl_bank_ram #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 11,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] store [WORDS];
    logic [DATA_W-1:0] pipe_d [LAT];
    logic [LAT-1:0]    pipe_v;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    // First stage: array read
    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_v[0] <= 1'b0;
        end else begin
            pipe_v[0] <= rd_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            pipe_d[0] <= store[rd_idx];
        end
    end

    // Remaining output registers
    genvar g;
    generate
        for (g = 1; g < LAT; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe_v[g] <= 1'b0;
                end else begin
                    pipe_v[g] <= pipe_v[g-1];
                end
            end
            always_ff @(posedge clk) begin
                if (pipe_v[g-1]) begin
                    pipe_d[g] <= pipe_d[g-1];
                end
            end
        end
    endgenerate

    assign rd_vld  = pipe_v[LAT-1];
    assign rd_data = pipe_d[LAT-1];

endmodule

// File: rtl/bbl_req_front.sv
module bbl_req_front
    import bbl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 11,
    parameter int BANK_W      = 17,
    parameter int OUTSTANDING = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank_id,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_more,
    input  logic              rsp_fire,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rd_hit,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CW     = $clog2(OUTSTANDING + 1);
    localparam int FIELDS = IDX_W + BANK_W;

    req_phase_e        phase_q;
    logic [IDX_W-1:0]  wr_idx_q;
    logic              wr_hit_q;
    logic [CW-1:0]     credit_q;

    logic              at_head;
    logic              room;
    logic              fire;
    logic              take_read;
    logic              take_whead;
    logic              take_wdata;
    logic              bank_eq;
    logic              unused_hi;

    assign at_head = (phase_q == PH_HEAD);
    assign room    = has_room(int'(credit_q), OUTSTANDING);

    // A header waits for a credit; a write data word is always taken
    assign req_ready  = at_head ? room : 1'b1;
    assign fire       = req_valid && req_ready;
    assign take_read  = fire && at_head && !req_more;
    assign take_whead = fire && at_head && req_more;
    assign take_wdata = fire && !at_head;

    assign bank_eq   = (req_data[IDX_W +: BANK_W] == bank_id);
    assign unused_hi = ^req_data[DATA_W-1:FIELDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_HEAD;
            wr_idx_q <= '0;
            wr_hit_q <= 1'b0;
        end else if (take_whead) begin
            phase_q  <= PH_WDATA;
            wr_idx_q <= req_data[IDX_W-1:0];
            wr_hit_q <= bank_eq;
        end else if (take_wdata) begin
            phase_q  <= PH_HEAD;
            wr_hit_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_q <= '0;
        end else begin
            case ({take_read, rsp_fire})
                2'b10:   credit_q <= credit_q + 1'b1;
                2'b01:   credit_q <= credit_q - 1'b1;
                default: credit_q <= credit_q;
            endcase
        end
    end

    assign rd_en   = take_read;
    assign rd_idx  = req_data[IDX_W-1:0];
    assign rd_hit  = bank_eq;
    assign wr_en   = take_wdata && wr_hit_q;
    assign wr_idx  = wr_idx_q;
    assign wr_data = req_data;

endmodule

// File: rtl/bcast_bank_leaf.sv
module bcast_bank_leaf
    import bbl_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int IDX_W       = DEF_IDX_W,
    parameter int BANK_W      = DEF_BANK_W,
    parameter int OUTSTANDING = DEF_OUTSTANDING,
    parameter int RAM_LAT     = DEF_RAM_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank_id,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_more,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int FLAG_DEPTH = (OUTSTANDING > 1) ? OUTSTANDING : 2;
    localparam int RSP_DEPTH  = FLAG_DEPTH;

    logic              rd_en;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_hit;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic              ram_vld;
    logic [DATA_W-1:0] ram_data;
    logic              flag_vld;
    logic              flag_hit;
    logic [DATA_W-1:0] masked;
    logic              rsp_fire;
    logic [63:0]       mask_wide;
    logic              unused_mask;

    assign rsp_fire = rsp_valid && rsp_ready;

    bbl_req_front #(
        .DATA_W      (DATA_W),
        .IDX_W       (IDX_W),
        .BANK_W      (BANK_W),
        .OUTSTANDING (OUTSTANDING)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .bank_id   (bank_id),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_data  (req_data),
        .req_more  (req_more),
        .rsp_fire  (rsp_fire),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_hit    (rd_hit),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    bbl_bank_ram #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .LAT    (RAM_LAT)
    ) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_vld  (ram_vld),
        .rd_data (ram_data)
    );

    // Hit flags travel beside the RAM pipeline
    bbl_sync_fifo #(
        .WIDTH (1),
        .DEPTH (FLAG_DEPTH)
    ) u_flags (
        .clk       (clk),
        .rst       (rst),
        .push      (rd_en),
        .push_data (rd_hit),
        .pop       (ram_vld),
        .out_valid (flag_vld),
        .out_data  (flag_hit)
    );

    assign mask_wide   = hit_mask(flag_vld && flag_hit);
    assign masked      = ram_data & mask_wide[DATA_W-1:0];
    assign unused_mask = ^mask_wide;

    // Response buffer sized to the credit limit
    bbl_sync_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (RSP_DEPTH)
    ) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .push      (ram_vld),
        .push_data (masked),
        .pop       (rsp_fire),
        .out_valid (rsp_valid),
        .out_data  (rsp_data)
    );

endmodule

// File: rtl/bbl_leaf_chk.sv
module bbl_leaf_chk #(
    parameter int DATA_W      = 32,
    parameter int OUTSTANDING = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_more,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data
);
    localparam int KW = $clog2(OUTSTANDING + 2) + 1;

    logic [KW-1:0] pend;
    logic          in_wdata;
    logic          acc;
    logic          rd_acc;

    assign acc    = req_valid && req_ready;
    assign rd_acc = acc && !in_wdata && !req_more;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            in_wdata <= 1'b0;
        end else begin
            if (acc) begin
                in_wdata <= !in_wdata && req_more;
            end
            case ({rd_acc, rsp_valid && rsp_ready})
                2'b10:   pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    // R1: no response without a pending read
    p_no_orphan_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (pend != '0));

    // R2: a write data word is never refused
    p_wdata_taken_r2: assert property (@(posedge clk) disable iff (rst)
        in_wdata |-> req_ready);

    // R8: pending reads stay within the credit limit
    p_credit_cap_r8: assert property (@(posedge clk) disable iff (rst)
        pend <= KW'(OUTSTANDING));

    // R8: header port stalls when the limit is reached
    p_stall_full_r8: assert property (@(posedge clk) disable iff (rst)
        ((pend == KW'(OUTSTANDING)) && !in_wdata) |-> !req_ready);

    // R9: a held response is not dropped or changed
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R10: quiet response port right after reset
    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && req_ready));

endmodule

bind bcast_bank_leaf bbl_leaf_chk #(
    .DATA_W      (DATA_W),
    .OUTSTANDING (OUTSTANDING)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_more  (req_more),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
);

// File: tb/bcast_bank_leaf_test.sv
module bcast_bank_leaf_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int IW    = 3;
    localparam int BW    = 3;
    localparam int OUTS  = 4;
    localparam int LAT   = 2;
    localparam int WORDS = 1 << IW;
    localparam int BANKS = 1 << BW;
    localparam logic [BW-1:0] MY_BANK = 3'd5;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [BW-1:0] bank_id = MY_BANK;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [DW-1:0] req_data = '0;
    logic          req_more = 1'b0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [DW-1:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    int rsp_seen = 0;
    int reads_sent = 0;
    int rsp_mode = 1;
    logic [7:0] lfsr = 8'hA5;

    logic [DW-1:0] ref_mem [WORDS];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bcast_bank_leaf #(
        .DATA_W      (DW),
        .IDX_W       (IW),
        .BANK_W      (BW),
        .OUTSTANDING (OUTS),
        .RAM_LAT     (LAT)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .bank_id   (bank_id),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_data  (req_data),
        .req_more  (req_more),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data)
    );

    task automatic check(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Header layout: [IW-1:0] index, [IW+BW-1:IW] bank, rest ignored
    function automatic logic [DW-1:0] hdr(input int bank, input int idx, input int junk);
        return DW'((junk << (IW + BW)) | (bank << IW) | idx);
    endfunction

    function automatic logic [DW-1:0] pattern(input int bank, input int idx, input int salt);
        return DW'(bank * 131 + idx * 17 + salt * 977 + 3);
    endfunction

    // Back-pressure driver: 0 = hold, 1 = always ready, 2 = pseudo-random
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rsp_ready <= (rsp_mode == 2) ? (lfsr[0] | lfsr[3]) : (rsp_mode == 1);
    end

    // Response monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst && rsp_valid && rsp_ready) begin
            rsp_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 response without pending read", rsp_data, '0);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_data == e, t, rsp_data, e);
            end
        end
    end

    task automatic put(input logic [DW-1:0] w, input logic more);
        req_valid = 1'b1;
        req_data  = w;
        req_more  = more;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int bank, input int idx, input int junk, input logic [DW-1:0] d);
        if (bank == int'(MY_BANK)) ref_mem[idx] = d;
        put(hdr(bank, idx, junk), 1'b1);
        put(d, 1'b0);
    endtask

    task automatic do_read(input int bank, input int idx, input int junk, input string tag);
        if (bank == int'(MY_BANK)) exp_q.push_back(ref_mem[idx]);
        else exp_q.push_back('0);
        tag_q.push_back(tag);
        reads_sent++;
        put(hdr(bank, idx, junk), 1'b0);
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: state after reset
        check(rsp_valid == 1'b0, "R10 rsp_valid after reset", DW'(rsp_valid), '0);
        check(req_ready == 1'b1, "R10 req_ready after reset", DW'(req_ready), DW'(1));

        // R2, R12, R3: fill every bank/index; only own bank may keep data
        for (int b = 0; b < BANKS; b++)
            for (int i = 0; i < WORDS; i++)
                do_write(b, i, (b ^ i) & 15, pattern(b, i, 0));
        repeat (8) @(negedge clk);
        check(rsp_seen == 0, "R2 writes produced responses", DW'(rsp_seen), '0);
        check(rsp_valid == 1'b0, "R2 rsp_valid after writes", DW'(rsp_valid), '0);

        // R4, R5, R6, R11, R12: sweep all reads under random back-pressure
        rsp_mode = 2;
        for (int b = 0; b < BANKS; b++)
            for (int i = 0; i < WORDS; i++)
                do_read(b, i, (b * 7 + i * 3) & 63,
                        (b == int'(MY_BANK)) ? "R4 R6 R11 R12 hit read" : "R5 R6 miss read");
        drain();

        // R7: read right after write to the same index
        for (int i = 0; i < WORDS; i++) begin
            do_write(int'(MY_BANK), i, 9, pattern(int'(MY_BANK), i, 1));
            do_read(int'(MY_BANK), i, 2, "R7 read after write");
        end
        // R12: foreign write followed by own read
        do_write(1, 4, 0, 16'hBEEF);
        do_read(int'(MY_BANK), 4, 0, "R12 foreign write ignored");
        drain();

        // R8, R9: hold responses, count reads accepted before stall
        rsp_mode = 0;
        repeat (3) @(negedge clk);
        begin
            int acc_cnt = 0;
            for (int k = 0; k < 12; k++) begin
                req_valid = 1'b1;
                req_more  = 1'b0;
                req_data  = hdr(int'(MY_BANK), acc_cnt % WORDS, 0);
                if (req_ready) begin
                    exp_q.push_back(ref_mem[acc_cnt % WORDS]);
                    tag_q.push_back("R8 R6 read after stall");
                    reads_sent++;
                    acc_cnt++;
                end
                @(negedge clk);
            end
            check(acc_cnt == OUTS, "R8 reads accepted while held", DW'(acc_cnt), DW'(OUTS));
            check(req_ready == 1'b0, "R8 req_ready at limit", DW'(req_ready), '0);
            req_valid = 1'b0;
        end
        begin
            logic [DW-1:0] held;
            check(rsp_valid == 1'b1, "R9 response pending", DW'(rsp_valid), DW'(1));
            held = rsp_data;
            repeat (3) @(negedge clk);
            check(rsp_valid == 1'b1, "R9 response kept", DW'(rsp_valid), DW'(1));
            check(rsp_data == held, "R9 response stable", rsp_data, held);
        end
        rsp_mode = 1;
        drain();
        repeat (6) @(negedge clk);

        // R1: one response per read, none left over
        check(exp_q.size() == 0, "R1 missing responses", DW'(exp_q.size()), '0);
        check(rsp_seen == reads_sent, "R1 response count", DW'(rsp_seen), DW'(reads_sent));
        check(rsp_valid == 1'b0, "R1 no extra response", DW'(rsp_valid), '0);
        finish_run();
    end

endmodule